// File: doc/BRIEF.md
# Linked Test Access Port Controller

This block is the test access port of one core that sits in a chain of such ports. An outside chain-linking circuit decides which port is active. The block holds the sixteen-state test controller, a four-bit instruction register, a one-bit bypass path and an optional identification register. Mode-select and serial data are sampled on the rising edge of the test clock. Every output moves only on the falling edge. An active-low reset puts the controller back in its reset state at once, even when the test clock is stopped.

The linking circuit drives `chain_en`. While it is low, the rising edges of the test clock do nothing: the controller and every shift register keep their values. The block reports two things back to the linking circuit. `data_out_vld` is high exactly while `data_out` carries shifted bits. `chain_instr_act` is high while the active instruction is one of the chain-linking instructions.

Top module: `tap_link_ctrl`

## Requirements
- R1: Driving `tap_rst_n` low at once, with no test-clock edge, sets the controller to its reset state, clears `data_out`, `data_out_vld` and `chain_instr_act`, and restores the reset instruction.
- R2: While `chain_en` is high, the controller follows the standard sixteen-state transition graph on each rising edge, using `mode_sel`.
- R3: While `chain_en` is low, rising edges leave the controller state, the instruction register and the data registers unchanged, so `data_out` and `data_out_vld` hold.
- R4: `data_out`, `data_out_vld` and `chain_instr_act` never change on a rising edge of `test_clk`.
- R5: `data_out_vld` is high exactly while the controller is in a shift state (instruction or data). Otherwise both `data_out_vld` and `data_out` are 0.
- R6: On capture into the instruction register, the register loads 0001, so the first four bits shifted out are 1, 0, 0, 0.
- R7: Instruction bits enter least significant bit first. The new instruction takes effect on the falling edge in the instruction-update state. Code 1111 selects the one-bit bypass path, which captures 0, so a data scan returns 0 and then the input delayed by one bit.
- R8: The reset instruction is code 0001, which selects a 32-bit identification register. A data scan returns `ID_VAL`, least significant bit first.
- R9: `chain_instr_act` is high exactly while the active instruction is 1000 or 1001 (top three bits 100). Both of these codes use the bypass path.
- R10: Any code other than 0001 selects the bypass path.
- R11: Five rising edges with `mode_sel` high and `chain_en` high reach the reset state from any state, and this restores instruction 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock, may stop at any time |
| tap_rst_n | input | 1 | Asynchronous active-low port reset |
| mode_sel | input | 1 | Mode select, sampled on the rising edge |
| data_in | input | 1 | Serial data in, sampled on the rising edge |
| chain_en | input | 1 | Port enable from the linking circuit (tie high when no linking circuit is present) |
| data_out | output | 1 | Serial data out, changes on the falling edge |
| data_out_vld | output | 1 | High while data_out carries shifted data |
| chain_instr_act | output | 1 | High while a chain-linking instruction is active |

## Verification
Two functions can land in the same clock cycle: the enable gate and the shift path. In a cycle where `chain_en` is low, the controller may already be in a shift state with `data_in` toggling. The bench provokes this in two ways. It drops the enable in the middle of a bypass scan. It also mixes a random enable into a random mode-select walk. It judges the result by checking that `data_out` and `data_out_vld` keep their values and that the scan resumes with no lost bit. It also checks that `data_out_vld` matches an independent controller model on every step.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    tap_st_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    mode,
  output tap_st_e st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st <= ST_RESET;
    else if (en) st <= tap_next(st, mode);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] RESET_OP = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            din,
  input  tap_st_e         st,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_cur,
  output logic            link_act
);
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_sr <= CAP_PAT;
    else if (en) begin
      if (st == ST_CAP_IR)     ir_sr <= CAP_PAT;
      else if (st == ST_SH_IR) ir_sr <= {din, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_cur   <= RESET_OP;
      link_act <= 1'b0;
    end else if (st == ST_RESET) begin
      ir_cur   <= RESET_OP;
      link_act <= 1'b0;
    end else if (st == ST_UPD_IR) begin
      ir_cur   <= ir_sr;
      link_act <= (ir_sr[IR_W-1:IR_W-3] == 3'b100);
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int ID_W = 32,
  parameter bit HAS_ID = 1'b1,
  parameter logic [ID_W-1:0] ID_VAL = '1,
  parameter logic [IR_W-1:0] ID_OP = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            din,
  input  tap_st_e         st,
  input  logic [IR_W-1:0] ir_cur,
  output logic            dr_bit
);
  logic byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else if (en) begin
      if (st == ST_CAP_DR)     byp_q <= 1'b0;
      else if (st == ST_SH_DR) byp_q <= din;
    end
  end

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) id_sr <= ID_VAL;
        else if (en) begin
          if (st == ST_CAP_DR)     id_sr <= ID_VAL;
          else if (st == ST_SH_DR) id_sr <= {din, id_sr[ID_W-1:1]};
        end
      end
      assign dr_bit = (ir_cur == ID_OP) ? id_sr[0] : byp_q;
    end else begin : g_noid
      assign dr_bit = byp_q;
    end
  endgenerate
endmodule

// File: rtl/tap_link_ctrl.sv
module tap_link_ctrl
  import tap_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int ID_W = 32,
  parameter bit HAS_ID = 1'b1,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1A5C_3E2B
) (
  input  logic test_clk,
  input  logic tap_rst_n,
  input  logic mode_sel,
  input  logic data_in,
  input  logic chain_en,
  output logic data_out,
  output logic data_out_vld,
  output logic chain_instr_act
);
  localparam logic [IR_W-1:0] ID_OP  = IR_W'(1);
  localparam logic [IR_W-1:0] BYP_OP = '1;
  localparam logic [IR_W-1:0] RST_OP = HAS_ID ? ID_OP : BYP_OP;

  tap_st_e         st;
  logic [IR_W-1:0] ir_sr, ir_cur;
  logic            dr_bit;

  tap_fsm u_fsm (
    .clk(test_clk), .rst_n(tap_rst_n), .en(chain_en), .mode(mode_sel), .st(st)
  );

  tap_ir #(.IR_W(IR_W), .RESET_OP(RST_OP)) u_ir (
    .clk(test_clk), .rst_n(tap_rst_n), .en(chain_en), .din(data_in), .st(st),
    .ir_sr(ir_sr), .ir_cur(ir_cur), .link_act(chain_instr_act)
  );

  tap_dr #(.IR_W(IR_W), .ID_W(ID_W), .HAS_ID(HAS_ID), .ID_VAL(ID_VAL), .ID_OP(ID_OP)) u_dr (
    .clk(test_clk), .rst_n(tap_rst_n), .en(chain_en), .din(data_in), .st(st),
    .ir_cur(ir_cur), .dr_bit(dr_bit)
  );

  always_ff @(negedge test_clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      data_out     <= 1'b0;
      data_out_vld <= 1'b0;
    end else begin
      case (st)
        ST_SH_DR: begin data_out <= dr_bit;   data_out_vld <= 1'b1; end
        ST_SH_IR: begin data_out <= ir_sr[0]; data_out_vld <= 1'b1; end
        default:  begin data_out <= 1'b0;     data_out_vld <= 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/tap_link_chk.sv
module tap_link_chk
  import tap_pkg::*;
#(
  parameter int IR_W = 4
) (
  input logic            test_clk,
  input logic            tap_rst_n,
  input logic            mode_sel,
  input logic            chain_en,
  input logic            data_out,
  input logic            data_out_vld,
  input logic            chain_instr_act,
  input tap_st_e         st,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_cur
);
  AST_QUIET_OUT: assert property (@(negedge test_clk) disable iff (!tap_rst_n)
    !data_out_vld |-> !data_out); // R5

  AST_VLD_IN_SHIFT: assert property (@(posedge test_clk) disable iff (!tap_rst_n)
    data_out_vld |-> (st == ST_SH_DR || st == ST_SH_IR)); // R5

  AST_HOLD_OFF: assert property (@(posedge test_clk) disable iff (!tap_rst_n)
    !chain_en |=> $stable(st)); // R3

  AST_RESET_STAYS: assert property (@(posedge test_clk) disable iff (!tap_rst_n)
    (chain_en && mode_sel && st == ST_RESET) |=> st == ST_RESET); // R2

  AST_CAP_PATTERN: assert property (@(posedge test_clk) disable iff (!tap_rst_n)
    (chain_en && st == ST_CAP_IR) |=> ir_sr[1:0] == 2'b01); // R6

  AST_LINK_CODE: assert property (@(posedge test_clk) disable iff (!tap_rst_n)
    chain_instr_act |-> ir_cur[IR_W-1:IR_W-3] == 3'b100); // R9
endmodule

bind tap_link_ctrl tap_link_chk #(.IR_W(IR_W)) u_chk (
  .test_clk(test_clk), .tap_rst_n(tap_rst_n), .mode_sel(mode_sel), .chain_en(chain_en),
  .data_out(data_out), .data_out_vld(data_out_vld), .chain_instr_act(chain_instr_act),
  .st(st), .ir_sr(ir_sr), .ir_cur(ir_cur)
);

// File: tb/sim_tap_link_ctrl.sv
`timescale 1ns/1ps
module sim_tap_link_ctrl;
  localparam int IRW = 4;
  localparam logic [31:0] IDV = 32'h1A5C_3E2B;

  logic clk = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, en = 1'b1;
  logic tdo, vld, lnk;
  int errs = 0, checks = 0;
  int ms = 0; // bench model state: 0 reset,1 idle,2 seldr,3 capdr,4 shdr,5 ex1dr,6 pausedr,7 ex2dr,8 upddr,9..15 IR side
  bit done = 0;

  always #4 clk = ~clk;

  tap_link_ctrl u0 (
    .test_clk(clk), .tap_rst_n(rst_n), .mode_sel(tms), .data_in(tdi), .chain_en(en),
    .data_out(tdo), .data_out_vld(vld), .chain_instr_act(lnk)
  );

  function automatic int mnext(int s, bit m);
    case (s)
      0: return m ? 0 : 1;   1: return m ? 2 : 1;
      2: return m ? 9 : 3;   3: return m ? 5 : 4;
      4: return m ? 5 : 4;   5: return m ? 8 : 6;
      6: return m ? 7 : 6;   7: return m ? 8 : 4;
      8: return m ? 2 : 1;   9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one test-clock step; called just after a falling edge
  task automatic step(bit m, bit d);
    logic [2:0] pre;
    tms = m; tdi = d;
    pre = {tdo, vld, lnk};
    @(posedge clk); #1;
    chk({tdo, vld, lnk} == pre, "R4 rising edge moved an output", {29'd0, tdo, vld, lnk}, {29'd0, pre});
    if (en) ms = mnext(ms, m);
    @(negedge clk); #1;
    chk(vld == (ms == 4 || ms == 11), "R5 valid flag vs state", {31'd0, vld}, {31'd0, (ms == 4 || ms == 11)});
    if (!vld) chk(tdo == 1'b0, "R5 output quiet", {31'd0, tdo}, 32'd0);
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
  endtask

  // from idle: load an instruction, return the captured bits, end in idle
  task automatic load_ir(logic [IRW-1:0] code, output logic [IRW-1:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < IRW; i++) begin
      cap[i] = tdo;
      step(i == IRW - 1, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  // from idle: scan n data bits, end in idle
  task automatic scan_dr(int n, logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [31:0] byp_exp(int n, logic [31:0] din);
    logic [31:0] r = '0;
    for (int i = 1; i < n; i++) r[i] = din[i-1];
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [IRW-1:0] cap;
    logic [31:0] d, r;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(vld == 0 && tdo == 0 && lnk == 0, "R1 reset outputs", {29'd0, tdo, vld, lnk}, 32'd0);
    rst_n = 1'b1; ms = 0;
    step(0, 0);
    // R8 reset instruction reads the identification value
    scan_dr(32, 32'h0, r);
    chk(r == IDV, "R8 identification scan", r, IDV);
    // R6 capture pattern and R7 bypass
    load_ir(4'hF, cap);
    chk(cap == 4'b0001, "R6 captured instruction bits", {28'd0, cap}, 32'd1);
    chk(lnk == 0, "R9 link flag off for bypass", {31'd0, lnk}, 32'd0);
    d = $urandom; scan_dr(16, d, r);
    chk(r[15:0] == byp_exp(16, d)[15:0], "R7 bypass delay", r, byp_exp(16, d));
    // R10 unassigned code acts as bypass
    load_ir(4'h5, cap);
    d = $urandom; scan_dr(12, d, r);
    chk(r[11:0] == byp_exp(12, d)[11:0], "R10 unassigned code bypass", r, byp_exp(12, d));
    // R9 link instructions
    load_ir(4'h8, cap);
    chk(lnk == 1, "R9 link flag for 1000", {31'd0, lnk}, 32'd1);
    d = $urandom; scan_dr(8, d, r);
    chk(r[7:0] == byp_exp(8, d)[7:0], "R9 link code uses bypass", r, byp_exp(8, d));
    load_ir(4'h3, cap);
    chk(lnk == 0, "R9 link flag cleared", {31'd0, lnk}, 32'd0);
    load_ir(4'h9, cap);
    chk(lnk == 1, "R9 link flag for 1001", {31'd0, lnk}, 32'd1);
    // R3 enable low in the middle of a bypass scan
    step(1, 0); step(0, 0); step(0, 0); step(0, 1); // shifted 1 into bypass
    chk(tdo == 1 && vld == 1, "R3 before hold", {30'd0, tdo, vld}, 32'd3);
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step($urandom_range(0, 1), 1'b0);
      chk(tdo == 1 && vld == 1, "R3 held while disabled", {30'd0, tdo, vld}, 32'd3);
    end
    en = 1'b1;
    step(0, 0);
    chk(tdo == 0, "R3 scan resumes without loss", {31'd0, tdo}, 32'd0);
    step(1, 0); step(1, 0); step(0, 0);
    // R1 asynchronous reset with no clock edge
    step(1, 0); step(0, 0); step(0, 0);
    chk(vld == 1 && lnk == 1, "R1 precondition", {30'd0, vld, lnk}, 32'd3);
    @(posedge clk); #2;
    rst_n = 1'b0; #1;
    chk(vld == 0 && lnk == 0 && tdo == 0, "R1 immediate clear", {29'd0, tdo, vld, lnk}, 32'd0);
    @(negedge clk); #1;
    rst_n = 1'b1; ms = 0;
    step(0, 0);
    scan_dr(32, 32'h0, r);
    chk(r == IDV, "R1 reset instruction restored", r, IDV);
    // R2 random walk with random enable
    for (int i = 0; i < 400; i++) begin
      en = ($urandom_range(0, 4) != 0);
      step($urandom_range(0, 1), $urandom_range(0, 1));
    end
    en = 1'b1;
    // R11 five highs reach reset and restore the identification instruction
    load_ir(4'hF, cap);
    step(1, 0); step(0, 0); step(1, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk(ms == 0 && lnk == 0, "R11 reset state by mode select", {31'd0, lnk}, 32'd0);
    step(0, 0);
    scan_dr(32, 32'h0, r);
    chk(r == IDV, "R11 identification after reset walk", r, IDV);
    // R2 directed pause loop through data path
    step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    chk(vld == 1, "R2 exit2 back to shift", {31'd0, vld}, 32'd1);
    step(1, 0); step(1, 0); step(0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule